// File: doc/BRIEF.md
# Command Queue Instruction Executor

This block is one execution thread of a command sequencer. It fetches 64-bit instructions from memory, one at a time, starting at a program counter and stopping when the counter reaches a programmed end address. It can write registers through a master port, with a write mask that an earlier instruction sets. It can jump by a relative or an absolute amount. It can stall on a hardware event and clear that event in the same step. It can also signal that a command buffer has completed. Because of this, a timing-critical register update, such as a display reconfiguration during blanking, can be prepared in memory ahead of time and then replayed by hardware at the moment an event arrives.

Software controls the thread through a few inputs. An enable input lets the thread start fetching. A suspend input holds the thread between instructions. While the thread is held, software can load a new program counter, and any instruction that was fetched but not yet executed is dropped. The end address can be reloaded at any time, so software can chain another buffer onto a thread that is already running. A warm reset input brings the thread back to idle.

Instruction layout:
- bits [63:56]: opcode
- bits [55:48]: subsystem
- bits [47:32]: register offset
- bits [31:0]: immediate

Opcodes:
- 0x02: set mask
- 0x04: register write
- 0x10: jump
- 0x20: event wait/clear
- 0x40: end of command

Top module: `cmdq_exec`

## Requirements
- R1: A write instruction (opcode 0x04) drives wr_en for exactly one cycle. During that cycle wr_subsys = bits [55:48], wr_offs = bits [47:32], wr_data = bits [31:0], and wr_mask = the current write mask.
- R2: A mask instruction (opcode 0x02) loads bits [31:0] into the write mask, and later writes use this mask. After reset the mask is 0xFFFFFFFF.
- R3: A jump (opcode 0x10) with bit 32 = 0 adds bits [31:0] to the PC. An offset of 8 therefore behaves as a no-op that moves on to the next instruction.
- R4: A jump with bit 32 = 1 loads bits [31:0] into the PC as an absolute address.
- R5: An event instruction (opcode 0x20) with bit 15 set stalls the thread. The event number is bits [36:32]. During the stall, waiting is high, pc stays on the instruction, and no fetch is made. Once ev_in[event] is high, the thread moves on. If bit 31 (update) is set, it pulses ev_clr[event] for one cycle.
- R6: An event instruction with bit 15 clear does not stall. If bit 31 is set, it pulses ev_clr[event] once.
- R7: An end-of-command instruction (opcode 0x40) pulses done for one cycle, and execution then continues with the next instruction. At most one of done, err and wr_en is high in any cycle.
- R8: No fetch is issued while pc equals the end address, or while en is low.
- R9: A thread that is suspended after a fetch holds the fetched instruction without executing it. A PC load in that state discards the instruction. After resume, execution continues from the loaded PC.
- R10: Any other opcode pulses err once. The thread then stops fetching, and pc stays unchanged, until a warm reset.
- R11: A warm reset, one cycle after it is applied, returns the thread to idle, drops any pending wait, and sets the mask to 0xFFFFFFFF.
- R12: Only one fetch is outstanding at a time. mem_req stays high, with a stable mem_addr equal to pc, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Allows the thread to fetch |
| susp | input | 1 | Hold between instructions |
| wreset | input | 1 | Warm reset of the thread |
| pc_ld | input | 1 | Load pc (accepted when idle or when suspended in execute) |
| pc_ld_val | input | AW | New pc value |
| end_ld | input | 1 | Load end address |
| end_ld_val | input | AW | New end address |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | AW | Fetch byte address |
| mem_ack | input | 1 | Fetch data valid |
| mem_rdata | input | 64 | Fetched instruction |
| wr_en | output | 1 | Register write strobe |
| wr_subsys | output | 8 | Target subsystem |
| wr_offs | output | 16 | Target register offset |
| wr_data | output | 32 | Write data |
| wr_mask | output | 32 | Write mask in effect |
| ev_in | input | NEV | Event levels |
| ev_clr | output | NEV | One-cycle event clear pulses |
| pc | output | AW | Current program counter |
| waiting | output | 1 | Stalled on an event |
| done | output | 1 | End-of-command pulse |
| err | output | 1 | Illegal-opcode pulse |

## Verification
The bench runs a program that contains a +8 jump, a forward relative skip over a poisoned write, and an absolute jump over a second poisoned write. If a jump took the wrong mode or the wrong offset, one of these poisoned writes would appear in the write log. One event instruction stalls and another only clears, so a design that stalled on the clear-only form, or that skipped the clear on the stalling form, would show a hang or a wrong count of clears. A suspend is applied while a fetch is in flight and is followed by a PC load. A design that did not flush the fetched instruction would issue the write that should have been dropped. The bench also checks that an illegal opcode, a warm reset during a wait, and a low enable each keep the thread from fetching, and that a warm reset restores the all-ones mask.

// File: rtl/cmdq_exec.sv
module cmdq_exec #(
  parameter int AW  = 32,
  parameter int NEV = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           susp,
  input  logic           wreset,
  input  logic           pc_ld,
  input  logic [AW-1:0]  pc_ld_val,
  input  logic           end_ld,
  input  logic [AW-1:0]  end_ld_val,
  output logic           mem_req,
  output logic [AW-1:0]  mem_addr,
  input  logic           mem_ack,
  input  logic [63:0]    mem_rdata,
  output logic           wr_en,
  output logic [7:0]     wr_subsys,
  output logic [15:0]    wr_offs,
  output logic [31:0]    wr_data,
  output logic [31:0]    wr_mask,
  input  logic [NEV-1:0] ev_in,
  output logic [NEV-1:0] ev_clr,
  output logic [AW-1:0]  pc,
  output logic           waiting,
  output logic           done,
  output logic           err
);
  localparam int EVW = (NEV > 1) ? $clog2(NEV) : 1;
  localparam logic [7:0] OP_MASK = 8'h02, OP_WR = 8'h04, OP_JMP = 8'h10,
                         OP_EV = 8'h20, OP_EOC = 8'h40;

  typedef enum logic [2:0] {S_RDY, S_FET, S_EXE, S_WT, S_ERR} st_t;

  st_t          st;
  logic [63:0]  ins;
  logic [AW-1:0] pc_q, end_q;
  logic [31:0]  mask_q;

  wire [7:0]     op     = ins[63:56];
  wire [31:0]    imm    = ins[31:0];
  wire [EVW-1:0] evid   = ins[32 +: EVW];
  wire           ev_hit = ev_in[evid];
  wire           run    = (st == S_EXE) && !susp;
  wire           legal  = (op == OP_MASK) || (op == OP_WR) || (op == OP_JMP) ||
                          (op == OP_EV) || (op == OP_EOC);
  wire [AW-1:0]  pc_seq = pc_q + AW'(8);
  wire           clr_go = ins[31] && ((run && op == OP_EV && !ins[15]) ||
                                      (st == S_WT && ev_hit));

  assign mem_req   = (st == S_FET);
  assign mem_addr  = pc_q;
  assign pc        = pc_q;
  assign waiting   = (st == S_WT);
  assign wr_en     = run && (op == OP_WR);
  assign wr_subsys = ins[55:48];
  assign wr_offs   = ins[47:32];
  assign wr_data   = imm;
  assign wr_mask   = mask_q;
  assign done      = run && (op == OP_EOC);
  assign err       = run && !legal;
  assign ev_clr    = clr_go ? (NEV'(1) << evid) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_RDY;
      ins    <= '0;
      pc_q   <= '0;
      end_q  <= '0;
      mask_q <= '1;
    end else begin
      if (end_ld) end_q <= end_ld_val;
      if (wreset) begin
        st     <= S_RDY;
        mask_q <= '1;
      end else begin
        unique case (st)
          S_RDY: begin
            if (pc_ld) pc_q <= pc_ld_val;
            else if (en && !susp && pc_q != end_q) st <= S_FET;
          end
          S_FET: begin
            if (mem_ack) begin
              ins <= mem_rdata;
              st  <= S_EXE;
            end
          end
          S_EXE: begin
            if (susp) begin
              if (pc_ld) begin
                pc_q <= pc_ld_val;
                st   <= S_RDY;
              end
            end else begin
              st <= S_RDY;
              case (op)
                OP_MASK: begin mask_q <= imm; pc_q <= pc_seq; end
                OP_WR, OP_EOC: pc_q <= pc_seq;
                OP_JMP: pc_q <= ins[32] ? AW'(imm) : pc_q + AW'(imm);
                OP_EV: begin
                  if (ins[15]) st <= S_WT;
                  else pc_q <= pc_seq;
                end
                default: st <= S_ERR;
              endcase
            end
          end
          S_WT: begin
            if (ev_hit) begin
              pc_q <= pc_seq;
              st   <= S_RDY;
            end
          end
          default: st <= S_ERR;
        endcase
      end
    end
  end

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !wreset) |=> (mem_req && $stable(mem_addr)));

  // R5
  wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> (!mem_req && !wr_en && !done));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !wreset) |=> (!mem_req && $stable(pc)));

  // R11
  wreset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wreset |=> (!waiting && wr_mask == 32'hFFFF_FFFF));

  // R8
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc == end_q && !mem_req && !pc_ld && !end_ld) |=> !mem_req);

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err, wr_en}));
endmodule

// File: tb/sim_cmdq_exec.sv
module sim_cmdq_exec;
  logic clk = 0, rst_n = 0;
  logic en = 0, susp = 0, wreset = 0, pc_ld = 0, end_ld = 0;
  logic [31:0] pc_ld_val = 0, end_ld_val = 0;
  logic mem_req, mem_ack = 0;
  logic [31:0] mem_addr;
  logic [63:0] mem_rdata = 0;
  logic wr_en, waiting, done, err;
  logic [7:0] wr_subsys;
  logic [15:0] wr_offs;
  logic [31:0] wr_data, wr_mask, ev_in = 0, ev_clr, pc;

  always #10 clk = ~clk;

  cmdq_exec u0 (.clk, .rst_n, .en, .susp, .wreset, .pc_ld, .pc_ld_val, .end_ld,
    .end_ld_val, .mem_req, .mem_addr, .mem_ack, .mem_rdata, .wr_en, .wr_subsys,
    .wr_offs, .wr_data, .wr_mask, .ev_in, .ev_clr, .pc, .waiting, .done, .err);

  logic [63:0] mem [0:63];
  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= mem[mem_addr[8:3]];
  end

  localparam logic [63:0] PROG [0:16] = '{
    64'h02_00_0000_0000FFFF, 64'h04_03_0010_12345678, 64'h10_00_0000_00000008,
    64'h10_00_0000_00000010, 64'h04_09_0000_DEADBEEF, 64'h20_00_0005_80008001,
    64'h20_00_0007_80000000, 64'h40_00_0000_00000001, 64'h10_00_0001_00000080,
    64'h04_09_0001_0BADF00D, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0,
    64'h04_01_0002_000000A5};
  localparam logic [87:0] EXP [0:1] = '{
    {8'h03, 16'h0010, 32'h12345678, 32'h0000FFFF},
    {8'h01, 16'h0002, 32'h000000A5, 32'h0000FFFF}};

  int total = 0, bad = 0;
  logic [87:0] wlog [0:15];
  int wcnt = 0, dcnt = 0, ecnt = 0, rcnt = 0;
  int clr [0:31];

  always @(negedge clk) begin
    if (wr_en) begin wlog[wcnt[3:0]] = {wr_subsys, wr_offs, wr_data, wr_mask}; wcnt++; end
    if (done) dcnt++;
    if (err) ecnt++;
    if (mem_req) rcnt++;
    for (int k = 0; k < 32; k++) if (ev_clr[k]) clr[k]++;
  end

  task automatic chk(input string tag, input logic [87:0] act, input logic [87:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic load(input logic [31:0] p, input logic [31:0] e);
    pc_ld = 1; pc_ld_val = p; end_ld = 1; end_ld_val = e;
    tick(1);
    pc_ld = 0; end_ld = 0;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = (i < 17) ? PROG[i] : 64'h0;
    for (int k = 0; k < 32; k++) clr[k] = 0;
    mem[32] = 64'h04_02_0000_00000001;
    mem[33] = 64'h04_02_0004_00000002;
    mem[34] = 64'h04_02_0008_00000003;
    mem[40] = 64'h77_00_0000_00000000;
    mem[41] = 64'h04_05_0006_00000007;
    mem[44] = 64'h20_00_0009_80008000;
    tick(3);
    @(negedge clk);
    chk("R2 reset mask", 88'(wr_mask), 88'hFFFFFFFF);
    chk("R12 reset idle", 88'({mem_req, waiting, pc}), 88'h0);
    rst_n = 1;
    tick(1);

    // main program: R1 R2 R3 R4 R5 R6 R7 R8
    load(32'h0, 32'h88);
    en = 1;
    for (int i = 0; i < 300 && !waiting; i++) @(negedge clk);
    chk("R5 stall pc", 88'({waiting, pc}), 88'({1'b1, 32'h28}));
    tick(5);
    @(negedge clk);
    chk("R5 still stalled", 88'({waiting, mem_req, pc}), 88'({2'b10, 32'h28}));
    tick(1);
    ev_in[5] = 1;
    for (int i = 0; i < 300 && clr[5] == 0; i++) @(negedge clk);
    tick(1);
    ev_in[5] = 0;
    for (int i = 0; i < 500 && pc != 32'h88; i++) @(negedge clk);
    tick(4);
    rcnt = 0;
    tick(10);
    @(negedge clk);
    chk("R8 stops at end", 88'({rcnt[7:0], pc}), 88'({8'h0, 32'h88}));
    chk("R1 write count", 88'(wcnt), 88'd2);
    for (int i = 0; i < 2; i++) chk("R1 R2 R3 R4 write fields", wlog[i], EXP[i]);
    chk("R5 wait clear once", 88'(clr[5]), 88'd1);
    chk("R6 clear only", 88'(clr[7]), 88'd1);
    chk("R7 done once", 88'({dcnt[7:0], ecnt[7:0]}), 88'h0100);

    // R9 suspend during fetch, flush with pc load
    wcnt = 0;
    load(32'h100, 32'h118);
    for (int i = 0; i < 300 && !(mem_req && mem_addr == 32'h108); i++) @(negedge clk);
    tick(1);
    susp = 1;
    tick(8);
    @(negedge clk);
    chk("R9 held", 88'({wcnt[7:0], pc}), 88'({8'd1, 32'h108}));
    tick(1);
    pc_ld = 1; pc_ld_val = 32'h110;
    tick(1);
    pc_ld = 0; susp = 0;
    for (int i = 0; i < 300 && pc != 32'h118; i++) @(negedge clk);
    tick(3);
    @(negedge clk);
    chk("R9 writes", 88'(wcnt), 88'd2);
    chk("R9 flushed", wlog[1], {8'h02, 16'h0008, 32'h3, 32'h0000FFFF});

    // R10 illegal opcode, R11 warm reset restores mask
    load(32'h140, 32'h150);
    for (int i = 0; i < 300 && ecnt == 0; i++) @(negedge clk);
    tick(2);
    rcnt = 0;
    tick(10);
    @(negedge clk);
    chk("R10 stopped", 88'({ecnt[7:0], rcnt[7:0], pc}), 88'({8'd1, 8'd0, 32'h140}));
    tick(1);
    en = 0; wreset = 1;
    tick(1);
    wreset = 0;
    wcnt = 0;
    load(32'h148, 32'h150);
    en = 1;
    for (int i = 0; i < 300 && wcnt == 0; i++) @(negedge clk);
    chk("R11 mask ones", wlog[0], {8'h05, 16'h0006, 32'h7, 32'hFFFFFFFF});

    // R11 warm reset drops a pending wait; R8 enable low blocks fetch
    tick(4);
    load(32'h160, 32'h170);
    for (int i = 0; i < 300 && !waiting; i++) @(negedge clk);
    tick(1);
    en = 0; wreset = 1;
    tick(1);
    wreset = 0;
    @(negedge clk);
    chk("R11 wait dropped", 88'(waiting), 88'd0);
    rcnt = 0;
    tick(10);
    @(negedge clk);
    chk("R8 enable low", 88'({rcnt[7:0], clr[9][7:0], pc}), 88'({16'h0, 32'h160}));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule